// File: doc/BRIEF.md
# Monitor-Mode Breakpoint and Watchpoint Unit

This block holds a small set of address comparators that watch a processor core's instruction fetch bus and its data access bus. In monitor mode a comparator hit does not stop the core. It raises an abort request toward the core instead, so the core keeps running and can still service interrupts while a debug handler inspects it. A hit on the fetch side requests a prefetch abort, and a hit on the data side requests a data abort. A sticky flag records that the abort came from the debug logic, so software can tell it apart from an abort raised by the memory system.

Each comparator unit is set up through a synchronous register-write port. The setup is an address value, an address mask, and a control word. The control word selects the bus and qualifies the hit by privilege, transfer direction, access size and an external condition input. A unit can also be chained to the unit below it. Software may rewrite a unit while accesses keep flowing. In the cycle a unit's register is written, that unit reports no hit. The block does not compare data values or address ranges. Enabling single-step or abort-vector catching while monitor mode is on raises a configuration-error flag.

Top module: `mon_dbg_unit`

## Requirements
- R1: Bit 4 of the global control register (register address 0) turns monitor mode on. While it is 0, no abort request is raised for any comparator hit. A write takes effect from the next cycle.
- R2: A fetch-side unit (control bit 1 = 0) that hits an access presented with `if_valid` raises `pabt_req` high in that same cycle and in no other cycle.
- R3: A data-side unit (control bit 1 = 1) that hits an access presented with `dt_valid` raises `dabt_req` high in that same cycle.
- R4: The address matches when `(addr ^ value) & ~mask` is zero. A mask bit of 1 means the bit is not compared. Unit u has its value at register address 4+4u, its mask at 5+4u and its control word at 6+4u. Control bit 0 enables the unit.
- R5: Control bits [3:2] qualify privilege: 01 hits only user accesses (priv = 0), 10 hits only privileged accesses (priv = 1), and 00 or 11 hit either.
- R6: For data-side units, control bits [5:4] qualify direction: 01 hits only reads (`dt_write` = 0), 10 hits only writes, and 00 or 11 hit both.
- R7: When control bit 6 is set, size is compared. A data-side unit requires `dt_size` to equal bits [8:7]. A fetch-side unit requires `if_state` to equal bit 7.
- R8: When control bit 9 is set, the unit hits only while `ext_cond` is 1.
- R9: A unit above unit 0 with control bit 10 set hits only if the unit directly below it hits in the same cycle. Unit 0 ignores bit 10.
- R10: A write to the value, mask or control register of a unit suppresses every hit of that unit in the same cycle. Other units are unaffected, and a write to register offset 3 of a unit suppresses nothing. The new value is used from the next cycle.
- R11: `mon_flag` becomes 1 in the cycle after any abort request and stays 1. Writing data bit 0 = 1 to register address 1 clears it. If an abort request and such a clear fall in the same cycle, the flag is set.
- R12: `cfg_err` is 1 while monitor mode is on and any of global control bits 0 (single-step), 1 (prefetch-abort vector catch) or 2 (data-abort vector catch) is set.
- R13: Reset clears every register. All units are disabled, monitor mode is off, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W (4) | Register address |
| reg_wdata | input | ADDR_W (32) | Register write data |
| if_valid | input | 1 | Fetch access valid |
| if_addr | input | ADDR_W (32) | Fetch address |
| if_priv | input | 1 | Fetch is privileged |
| if_state | input | 1 | Instruction-set state (fetch size) |
| dt_valid | input | 1 | Data access valid |
| dt_addr | input | ADDR_W (32) | Data address |
| dt_priv | input | 1 | Data access is privileged |
| dt_write | input | 1 | Data access is a write |
| dt_size | input | 2 | Data access size code |
| ext_cond | input | 1 | External match condition |
| pabt_req | output | 1 | Prefetch abort request |
| dabt_req | output | 1 | Data abort request |
| mon_flag | output | 1 | Sticky debug-abort status |
| cfg_err | output | 1 | Forbidden setting while in monitor mode |

## Verification
Two cases can fall in the same cycle. The first is a register write to a unit together with an access that the unit would hit. The bench drives the write and the access in one cycle and expects no abort. It then repeats the access alone and expects the abort, and it writes a different unit during a hit and expects the abort to survive. The second is an abort request together with a software clear of the status flag. The bench expects the flag to stay set. The chain case is also provoked, with a fetch hit and a data hit presented together and then apart. A behavioural model in the bench judges every output on every cycle.

// File: rtl/mdu_pkg.sv
// Package: shared control-word layout for the monitor-mode debug unit.
// Assumes: the control word occupies the low CTL_W bits of a register write.
package mdu_pkg;
    localparam int CTL_W = 11;

    // Comparator control word, bit 0 at the bottom.
    typedef struct packed {
        logic       chain;     // [10] require lower unit to hit
        logic       ext_req;   // [9]  require external condition
        logic [1:0] size;      // [8:7] size value
        logic       size_chk;  // [6]  compare size
        logic [1:0] dir;       // [5:4] direction qualifier
        logic [1:0] priv;      // [3:2] privilege qualifier
        logic       is_data;   // [1]  0 fetch bus, 1 data bus
        logic       en;        // [0]  unit enable
    } unit_ctl_t;

    localparam logic [1:0] Q_LOW  = 2'b01; // user-only / read-only
    localparam logic [1:0] Q_HIGH = 2'b10; // privileged-only / write-only
endpackage

// File: rtl/mdu_regs.sv
// Module: register bank of the debug unit (global control plus per-unit
// value, mask and control). Write-only synchronous port.
// Assumes: slot 0 of the address space is global, slot u+1 is unit u.
module mdu_regs
    import mdu_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 32,
    parameter int RA_W      = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 reg_we,
    input  logic [RA_W-1:0]                      reg_addr,
    input  logic [ADDR_W-1:0]                    reg_wdata,
    output logic                                 mon_en,
    output logic [2:0]                           forbid_bits,
    output logic                                 stat_clr,
    output logic [NUM_UNITS-1:0][ADDR_W-1:0]     unit_val,
    output logic [NUM_UNITS-1:0][ADDR_W-1:0]     unit_msk,
    output unit_ctl_t [NUM_UNITS-1:0]            unit_ctl,
    output logic [NUM_UNITS-1:0]                 wr_hit
);
    localparam int SLOT_W = RA_W - 2;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        field;
    logic              unused_wdata;

    assign slot         = reg_addr[RA_W-1:2];
    assign field        = reg_addr[1:0];
    assign unused_wdata = ^{reg_wdata[ADDR_W-1:CTL_W], reg_wdata[3]};

    // Status clear strobe: write of 1 to bit 0 at global address 1.
    assign stat_clr = reg_we && (slot == '0) && (field == 2'd1) && reg_wdata[0];

    // Global control register: monitor enable and forbidden-feature bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_en      <= 1'b0;
            forbid_bits <= '0;
        end else if (reg_we && (slot == '0) && (field == 2'd0)) begin
            mon_en      <= reg_wdata[4];
            forbid_bits <= reg_wdata[2:0];
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(u + 1);

        // Write strobe for this unit's value, mask or control register.
        assign wr_hit[u] = reg_we && (slot == MY_SLOT) && (field != 2'd3);

        // Per-unit registers, loaded by field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                unit_val[u] <= '0;
                unit_msk[u] <= '0;
                unit_ctl[u] <= '0;
            end else if (wr_hit[u]) begin
                case (field)
                    2'd0:    unit_val[u] <= reg_wdata;
                    2'd1:    unit_msk[u] <= reg_wdata;
                    default: unit_ctl[u] <= unit_ctl_t'(reg_wdata[CTL_W-1:0]);
                endcase
            end
        end
    end
endmodule

// File: rtl/mdu_cmp.sv
// Module: one comparator unit. Selects the fetch or data bus, then
// qualifies an address-with-mask match by privilege, direction, size and
// external condition. Combinational; chaining is applied by the parent.
// Assumes: 'hold' is high in a cycle when this unit's registers are written.
module mdu_cmp
    import mdu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] val,
    input  logic [ADDR_W-1:0] msk,
    input  unit_ctl_t         ctl,
    input  logic              hold,
    input  logic              if_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              if_priv,
    input  logic              if_state,
    input  logic              dt_valid,
    input  logic [ADDR_W-1:0] dt_addr,
    input  logic              dt_priv,
    input  logic              dt_write,
    input  logic [1:0]        dt_size,
    input  logic              ext_cond,
    output logic              hit
);
    logic              bus_valid;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_priv;
    logic              addr_ok, priv_ok, dir_ok, size_ok, ext_ok;

    // Bus selection by unit kind.
    always_comb begin
        bus_valid = ctl.is_data ? dt_valid : if_valid;
        bus_addr  = ctl.is_data ? dt_addr  : if_addr;
        bus_priv  = ctl.is_data ? dt_priv  : if_priv;
    end

    // Individual qualifiers.
    always_comb begin
        addr_ok = ((bus_addr ^ val) & ~msk) == '0;
        case (ctl.priv)
            Q_LOW:   priv_ok = !bus_priv;
            Q_HIGH:  priv_ok = bus_priv;
            default: priv_ok = 1'b1;
        endcase
        if (!ctl.is_data)          dir_ok = 1'b1;
        else if (ctl.dir == Q_LOW) dir_ok = !dt_write;
        else if (ctl.dir == Q_HIGH) dir_ok = dt_write;
        else                       dir_ok = 1'b1;
        if (!ctl.size_chk)         size_ok = 1'b1;
        else if (ctl.is_data)      size_ok = (dt_size == ctl.size);
        else                       size_ok = (if_state == ctl.size[0]);
        ext_ok = !ctl.ext_req || ext_cond;
    end

    // Final unchained hit.
    assign hit = ctl.en && !hold && bus_valid && addr_ok && priv_ok
                 && dir_ok && size_ok && ext_ok;
endmodule

// File: rtl/mon_dbg_unit.sv
// Module: monitor-mode breakpoint/watchpoint unit (top). Combines the
// comparator hits with chaining and turns them into abort requests that
// are high in the same cycle as the matching access. Keeps the sticky
// debug-abort flag and reports forbidden settings.
// Assumes: NUM_UNITS+1 slots fit in the register address space.
module mon_dbg_unit
    import mdu_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 32,
    parameter int RA_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              if_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              if_priv,
    input  logic              if_state,
    input  logic              dt_valid,
    input  logic [ADDR_W-1:0] dt_addr,
    input  logic              dt_priv,
    input  logic              dt_write,
    input  logic [1:0]        dt_size,
    input  logic              ext_cond,
    output logic              pabt_req,
    output logic              dabt_req,
    output logic              mon_flag,
    output logic              cfg_err
);
    logic                             mon_en;
    logic [2:0]                       forbid_bits;
    logic                             stat_clr;
    logic [NUM_UNITS-1:0][ADDR_W-1:0] unit_val;
    logic [NUM_UNITS-1:0][ADDR_W-1:0] unit_msk;
    unit_ctl_t [NUM_UNITS-1:0]        unit_ctl;
    logic [NUM_UNITS-1:0]             wr_hit;
    logic [NUM_UNITS-1:0]             raw_hit;
    logic [NUM_UNITS-1:0]             hit;
    logic [NUM_UNITS-1:0]             side_data;

    mdu_regs #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .RA_W(RA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mon_en(mon_en), .forbid_bits(forbid_bits),
        .stat_clr(stat_clr), .unit_val(unit_val), .unit_msk(unit_msk),
        .unit_ctl(unit_ctl), .wr_hit(wr_hit)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cmp
        mdu_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .val(unit_val[u]), .msk(unit_msk[u]), .ctl(unit_ctl[u]),
            .hold(wr_hit[u]),
            .if_valid(if_valid), .if_addr(if_addr), .if_priv(if_priv),
            .if_state(if_state),
            .dt_valid(dt_valid), .dt_addr(dt_addr), .dt_priv(dt_priv),
            .dt_write(dt_write), .dt_size(dt_size),
            .ext_cond(ext_cond), .hit(raw_hit[u])
        );
        assign side_data[u] = unit_ctl[u].is_data;
    end

    // Chain resolution: a chained unit needs the unit below it to hit.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (u == 0) hit[u] = raw_hit[u];
            else        hit[u] = raw_hit[u] && (!unit_ctl[u].chain || hit[u-1]);
        end
    end

    // Abort requests, aligned with the access strobe.
    assign pabt_req = mon_en && |(hit & ~side_data);
    assign dabt_req = mon_en && |(hit & side_data);

    // Forbidden features while monitor mode is on.
    assign cfg_err = mon_en && |forbid_bits;

    // Sticky debug-abort flag; a new abort wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     mon_flag <= 1'b0;
        else if (pabt_req || dabt_req)  mon_flag <= 1'b1;
        else if (stat_clr)              mon_flag <= 1'b0;
    end
endmodule

// File: rtl/mdu_check.sv
// Module: assertion checker for mon_dbg_unit, attached with bind below.
// Assumes: register address 0 is global control, 1 is status.
module mdu_check #(
    parameter int ADDR_W = 32,
    parameter int RA_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [RA_W-1:0]   reg_addr,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              if_valid,
    input logic              dt_valid,
    input logic              pabt_req,
    input logic              dabt_req,
    input logic              mon_flag,
    input logic              cfg_err,
    input logic              mon_en
);
    logic unused_chk;
    assign unused_chk = ^reg_wdata;

    a_r2_pabt_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pabt_req |-> (if_valid && mon_en));
    a_r3_dabt_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        dabt_req |-> (dt_valid && mon_en));
    a_r1_mode_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0) |=> (mon_en == $past(reg_wdata[4])));
    a_r11_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pabt_req || dabt_req) |=> mon_flag);
    a_r11_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_W'(1) && reg_wdata[0] && !pabt_req && !dabt_req)
        |=> !mon_flag);
    a_r11_flag_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_flag && !pabt_req && !dabt_req) |=> !mon_flag);
    a_r12_err_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> mon_en);
endmodule

bind mon_dbg_unit mdu_check #(.ADDR_W(ADDR_W), .RA_W(RA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .if_valid(if_valid), .dt_valid(dt_valid),
    .pabt_req(pabt_req), .dabt_req(dabt_req), .mon_flag(mon_flag),
    .cfg_err(cfg_err), .mon_en(mon_en)
);

// File: tb/sim_mon_dbg_unit.sv
`timescale 1ns/1ps
// Bench: drives directed access patterns and compares every output on
// every cycle against a behavioural model kept in plain variables.
module sim_mon_dbg_unit;
    localparam int AW = 32;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [RW-1:0] reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic          if_valid = 1'b0, if_priv = 1'b0, if_state = 1'b0;
    logic [AW-1:0] if_addr = '0, dt_addr = '0;
    logic          dt_valid = 1'b0, dt_priv = 1'b0, dt_write = 1'b0;
    logic [1:0]    dt_size = '0;
    logic          ext_cond = 1'b0;
    logic          pabt_req, dabt_req, mon_flag, cfg_err;

    always #10 clk = ~clk;

    mon_dbg_unit u0 (.*);

    // Behavioural model state.
    logic [31:0] mv [2];
    logic [31:0] mm [2];
    logic [31:0] mc [2];
    logic [31:0] mg;
    bit          mf;
    int          checks = 0, fails = 0;
    bit          done = 0;

    function automatic logic [31:0] ctlw(bit en, bit isd, int pq, int dq,
                                         bit szc, int sz, bit ext, bit chn);
        return {21'd0, chn, ext, sz[1:0], szc, dq[1:0], pq[1:0], isd, en};
    endfunction

    function automatic bit unit_hits(int u);
        bit isd, v, p;
        logic [31:0] a, c;
        c = mc[u];
        if (!c[0]) return 0;
        if (reg_we && int'(reg_addr) >= 4 + 4*u && int'(reg_addr) <= 6 + 4*u) return 0;
        isd = c[1];
        v = isd ? dt_valid : if_valid;
        a = isd ? dt_addr : if_addr;
        p = isd ? dt_priv : if_priv;
        if (!v) return 0;
        if (((a ^ mv[u]) & ~mm[u]) != 0) return 0;
        if (c[3:2] == 2'b01 && p) return 0;
        if (c[3:2] == 2'b10 && !p) return 0;
        if (isd && c[5:4] == 2'b01 && dt_write) return 0;
        if (isd && c[5:4] == 2'b10 && !dt_write) return 0;
        if (c[6]) begin
            if (isd && dt_size != c[8:7]) return 0;
            if (!isd && if_state != c[7]) return 0;
        end
        if (c[9] && !ext_cond) return 0;
        return 1;
    endfunction

    task automatic chk(string tag, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic tick(string tag);
        bit h0, h1, ep, ed;
        #5;
        h0 = unit_hits(0);
        h1 = unit_hits(1) && (!mc[1][10] || h0);
        ep = mg[4] && ((h0 && !mc[0][1]) || (h1 && !mc[1][1]));
        ed = mg[4] && ((h0 && mc[0][1]) || (h1 && mc[1][1]));
        if (!rst_n) begin ep = 0; ed = 0; end
        chk(tag, "pabt_req", pabt_req, ep);
        chk(tag, "dabt_req", dabt_req, ed);
        chk(tag, "mon_flag", mon_flag, mf);
        chk(tag, "cfg_err", cfg_err, mg[4] && (mg[2:0] != 0));
        @(posedge clk);
        #1;
        if (!rst_n) begin
            mv = '{0, 0}; mm = '{0, 0}; mc = '{0, 0}; mg = 0; mf = 0;
        end else begin
            if (ep || ed) mf = 1;
            else if (reg_we && reg_addr == 1 && reg_wdata[0]) mf = 0;
            if (reg_we) begin
                case (reg_addr)
                    4'd0:  mg = reg_wdata;
                    4'd4:  mv[0] = reg_wdata;
                    4'd5:  mm[0] = reg_wdata;
                    4'd6:  mc[0] = reg_wdata & 32'h7FF;
                    4'd8:  mv[1] = reg_wdata;
                    4'd9:  mm[1] = reg_wdata;
                    4'd10: mc[1] = reg_wdata & 32'h7FF;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        reg_we = 0; if_valid = 0; dt_valid = 0; ext_cond = 0;
    endtask

    task automatic set_wr(int a, logic [31:0] d);
        reg_we = 1; reg_addr = RW'(a); reg_wdata = d;
    endtask
    task automatic set_fe(logic [31:0] a, bit p, bit st);
        if_valid = 1; if_addr = a; if_priv = p; if_state = st;
    endtask
    task automatic set_da(logic [31:0] a, bit p, bit w, int sz);
        dt_valid = 1; dt_addr = a; dt_priv = p; dt_write = w; dt_size = sz[1:0];
    endtask
    task automatic wr(int a, logic [31:0] d, string tag);
        set_wr(a, d); tick(tag);
    endtask
    task automatic fe(logic [31:0] a, bit p, bit st, string tag);
        set_fe(a, p, st); tick(tag);
    endtask
    task automatic da(logic [31:0] a, bit p, bit w, int sz, string tag);
        set_da(a, p, w, sz); tick(tag);
    endtask

    initial begin
        mv = '{0, 0}; mm = '{0, 0}; mc = '{0, 0}; mg = 0; mf = 0;
        @(negedge clk);
        // Reset state, with traffic present.
        set_fe(32'h0, 0, 0); set_da(32'h0, 0, 0, 0); tick("R13");
        rst_n = 1;
        set_fe(32'h0, 0, 0); set_da(32'h0, 0, 0, 0); tick("R13");

        // Unit 0 as a fetch breakpoint, monitor mode still off.
        wr(4, 32'h1000, "R4"); wr(5, 0, "R4");
        wr(6, ctlw(1, 0, 0, 0, 0, 0, 0, 0), "R2");
        fe(32'h1000, 0, 0, "R1");
        wr(0, 32'h10, "R1");
        fe(32'h1000, 0, 0, "R2");
        fe(32'h2000, 0, 0, "R11");
        wr(1, 1, "R11");
        fe(32'h2000, 0, 0, "R11");

        // Mask: low nibble ignored.
        wr(5, 32'hF, "R4");
        fe(32'h100C, 0, 0, "R4");
        fe(32'h1010, 0, 0, "R4");
        wr(5, 0, "R4");

        // Unit 1 as a write-only watchpoint.
        wr(8, 32'h4000, "R3"); wr(9, 0, "R3");
        wr(10, ctlw(1, 1, 0, 2, 0, 0, 0, 0), "R6");
        da(32'h4000, 0, 0, 0, "R6");
        da(32'h4000, 0, 1, 0, "R3");
        wr(10, ctlw(1, 1, 0, 1, 0, 0, 0, 0), "R6");
        da(32'h4000, 0, 1, 0, "R6");
        da(32'h4000, 0, 0, 0, "R6");

        // Privilege qualifier.
        wr(10, ctlw(1, 1, 1, 0, 0, 0, 0, 0), "R5");
        da(32'h4000, 1, 0, 0, "R5");
        da(32'h4000, 0, 0, 0, "R5");
        wr(6, ctlw(1, 0, 2, 0, 0, 0, 0, 0), "R5");
        fe(32'h1000, 0, 0, "R5");
        fe(32'h1000, 1, 0, "R5");

        // Size qualifiers.
        wr(10, ctlw(1, 1, 0, 0, 1, 2, 0, 0), "R7");
        da(32'h4000, 0, 0, 2, "R7");
        da(32'h4000, 0, 0, 1, "R7");
        wr(6, ctlw(1, 0, 0, 0, 1, 1, 0, 0), "R7");
        fe(32'h1000, 0, 1, "R7");
        fe(32'h1000, 0, 0, "R7");

        // External condition.
        wr(6, ctlw(1, 0, 0, 0, 0, 0, 1, 0), "R8");
        fe(32'h1000, 0, 0, "R8");
        ext_cond = 1; fe(32'h1000, 0, 0, "R8");

        // Chaining unit 1 onto unit 0.
        wr(6, ctlw(1, 0, 0, 0, 0, 0, 0, 0), "R9");
        wr(10, ctlw(1, 1, 0, 0, 0, 0, 0, 1), "R9");
        da(32'h4000, 0, 0, 0, "R9");
        set_fe(32'h1000, 0, 0); set_da(32'h4000, 0, 0, 0); tick("R9");
        set_fe(32'h1008, 0, 0); set_da(32'h4000, 0, 0, 0); tick("R9");
        wr(6, ctlw(1, 0, 0, 0, 0, 0, 0, 1), "R9");
        fe(32'h1000, 0, 0, "R9");

        // Suppression while a unit is being written.
        wr(6, ctlw(1, 0, 0, 0, 0, 0, 0, 0), "R10");
        set_wr(4, 32'h3000); set_fe(32'h1000, 0, 0); tick("R10");
        fe(32'h1000, 0, 0, "R10");
        fe(32'h3000, 0, 0, "R10");
        set_wr(5, 0); set_fe(32'h3000, 0, 0); tick("R10");
        set_wr(6, ctlw(1, 0, 0, 0, 0, 0, 0, 0)); set_fe(32'h3000, 0, 0); tick("R10");
        set_wr(9, 0); set_fe(32'h3000, 0, 0); tick("R10");
        set_wr(7, 32'hFFFF); set_fe(32'h3000, 0, 0); tick("R10");

        // Abort and status clear together: set wins.
        set_wr(1, 1); set_fe(32'h3000, 0, 0); tick("R11");
        wr(1, 1, "R11");
        fe(32'h0, 0, 0, "R11");

        // Forbidden settings.
        wr(0, 32'h11, "R12");
        fe(32'h3000, 0, 0, "R12");
        wr(0, 32'h06, "R12");
        fe(32'h3000, 0, 0, "R1");
        set_da(32'h4000, 0, 0, 0); set_fe(32'h3000, 0, 0); tick("R1");
        wr(0, 32'h14, "R12");
        wr(0, 32'h10, "R12");
        fe(32'h3000, 0, 0, "R2");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule